// File: doc/BRIEF.md
# Interleaved Lane Phase Aligner

The block gathers sample words from four time-interleaved converter lanes. Each lane takes its sample on its own quarter of a common divided clock. The aligner moves all four words onto the lane-0 phase, so that one wide output word carries four consecutive samples side by side. A downstream parallel equalizer can then take that word at the slow rate.

A free-running counter on the fast clock produces four one-hot phase enables. The enables are brought out so that the sources know when to present their words. Lane n is captured during phase n.

Three retiming stages follow the capture registers. In each stage, every lane is taken on the phase of the lane before it, or on phase 0 once it has reached phase 0. Lanes 0 and 1 line up after the first stage, lanes 0 to 2 after the second, and all four after the third. No FIFO is used. A strobe travels with every lane, so an output word is flagged valid only when all four of its samples were strobed.

Top module: `lane_phase_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `align_word_o` = 0, `align_valid_o` = 0 and `phase_o` = 4'b0001.
- R2: Out of reset, `phase_o` is one-hot. It starts at bit 0 in the first cycle after reset and moves up one bit per clock, wrapping from bit 3 to bit 0. Bit p set means phase p is active.
- R3: Lane n's word (`ch_word_i[3n+2:3n]`) and strobe (`ch_strobe_i[n]`) are sampled only at the clock edge that ends a cycle with `phase_o[n]` set. Their values in any other cycle have no effect on the outputs.
- R4: The output packs lane 3 in bits [11:9], lane 2 in [8:6], lane 1 in [5:3] and lane 0 in [2:0], so lane 0 holds the oldest sample of the group.
- R5: The group presented in cycles c (phase 0) through c+3 appears on `align_word_o` from cycle c+13 to cycle c+16.
- R6: `align_valid_o` is high for at most one cycle in four, and only in a cycle where `phase_o[1]` is set. `align_word_o` changes only at the start of such a cycle.
- R7: A group raises `align_valid_o` in cycle c+13 if and only if all four lanes had their strobe high in their own phase cycle. A strobe held high outside its lane's phase does not make up for a missing one.
- R8: No valid pulse appears before cycle 13 after reset, and `align_word_o` is 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per group |
| rst | input | 1 | Synchronous active-high reset |
| ch_word_i | input | 12 | Lane words, lane n in bits [3n+2:3n] |
| ch_strobe_i | input | 4 | Per-lane sample-present strobe |
| phase_o | output | 4 | One-hot active phase enable |
| align_word_o | output | 12 | Aligned group of four samples |
| align_valid_o | output | 1 | One-cycle pulse marking a complete group |

## Verification
In the cycle that ends with phase 0 active, two things happen at once. Lane 0 captures the first sample of a new group, and the last retiming stage loads the previous group. Lane 3's older word must still reach the output intact. The bench provokes this by running ramp and random sample streams back to back, and by driving random junk on every lane and strobe outside its own phase. Each cycle it compares the output word and the valid flag against a model built from the time-indexed sample and strobe arrays, so any lane that picks up a neighbouring group or a junk value shows as a mismatch. Directed groups with no strobes, or with only lane 3 missing, show whether the valid flag is judged per group.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  // Phase on which a lane is registered in retiming stage 'stage'.
  // Stage 0 is the capture stage (each lane on its own phase); each later
  // stage moves every lane one phase earlier, stopping at phase 0.
  function automatic int retime_phase(int stage, int lane);
    return (lane > stage) ? (lane - stage) : 0;
  endfunction

endpackage

// File: rtl/lane_phase_gen.sv
module lane_phase_gen #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NCH-1:0] phase_en
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  for (genvar p = 0; p < NCH; p++) begin : g_dec
    assign phase_en[p] = (cnt_q == CW'(p));
  end
endmodule

// File: rtl/lane_align_stage.sv
module lane_align_stage #(
  parameter int NCH = 4,
  parameter int W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   lane_en,
  input  logic [NCH*W-1:0] d_i,
  input  logic [NCH-1:0]   v_i,
  output logic [NCH*W-1:0] q_o,
  output logic [NCH-1:0]   v_o
);
  for (genvar ln = 0; ln < NCH; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o[ln*W +: W] <= '0;
        v_o[ln]        <= 1'b0;
      end else if (lane_en[ln]) begin
        q_o[ln*W +: W] <= d_i[ln*W +: W];
        v_o[ln]        <= v_i[ln];
      end
    end
  end
endmodule

// File: rtl/lane_phase_aligner.sv
module lane_phase_aligner #(
  parameter int NCH = 4,
  parameter int W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH*W-1:0] ch_word_i,
  input  logic [NCH-1:0]   ch_strobe_i,
  output logic [NCH-1:0]   phase_o,
  output logic [NCH*W-1:0] align_word_o,
  output logic             align_valid_o
);
  // Stage 0 captures; stages 1..NCH-1 retime toward phase 0.
  localparam int NST = NCH;

  logic [NCH-1:0]   phase_en;
  logic [NCH-1:0]   st_en [NST];
  logic [NCH*W-1:0] st_d  [NST];
  logic [NCH-1:0]   st_v  [NST];
  logic             load_q;

  lane_phase_gen #(.NCH(NCH)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_en (phase_en)
  );

  for (genvar s = 0; s < NST; s++) begin : g_stage
    logic [NCH*W-1:0] din;
    logic [NCH-1:0]   vin;

    for (genvar ln = 0; ln < NCH; ln++) begin : g_en
      localparam int PH = lane_align_pkg::retime_phase(s, ln);
      assign st_en[s][ln] = phase_en[PH];
    end

    if (s == 0) begin : g_first
      assign din = ch_word_i;
      assign vin = ch_strobe_i;
    end else begin : g_next
      assign din = st_d[s-1];
      assign vin = st_v[s-1];
    end

    lane_align_stage #(.NCH(NCH), .W(W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .lane_en (st_en[s]),
      .d_i     (din),
      .v_i     (vin),
      .q_o     (st_d[s]),
      .v_o     (st_v[s])
    );
  end

  // Marks the single cycle right after the final stage has loaded.
  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= phase_en[0];
  end

  assign phase_o       = phase_en;
  assign align_word_o  = st_d[NST-1];
  assign align_valid_o = load_q & (&st_v[NST-1]);
endmodule

// File: rtl/lane_phase_aligner_chk.sv
module lane_phase_aligner_chk #(
  parameter int NCH = 4,
  parameter int W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   phase_o,
  input logic [NCH*W-1:0] align_word_o,
  input logic             align_valid_o
);
  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_o) == 1);

  assert_phase_rotate_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_o == {$past(phase_o[NCH-2:0]), $past(phase_o[NCH-1])});

  assert_valid_on_phase1_R6: assert property (@(posedge clk) disable iff (rst)
    align_valid_o |-> phase_o[1]);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    align_valid_o |=> !align_valid_o);

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !phase_o[1] |-> $stable(align_word_o));
endmodule

bind lane_phase_aligner lane_phase_aligner_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .phase_o       (phase_o),
  .align_word_o  (align_word_o),
  .align_valid_o (align_valid_o)
);

// File: tb/test_lane_phase_aligner.sv
module test_lane_phase_aligner;
  localparam int NCH  = 4;
  localparam int W    = 3;
  localparam int TMAX = 480;
  localparam int NGRP = TMAX / 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic [11:0]     ch_word;
  logic [3:0]      ch_strobe;
  logic [3:0]      phase;
  logic [11:0]     word;
  logic            valid;

  int checks = 0;
  int errors = 0;
  int cur_t  = -1;
  bit done   = 1'b0;

  logic [2:0] samp    [TMAX];
  logic [3:0] grp_stb [NGRP];

  lane_phase_aligner #(.NCH(NCH), .W(W)) i_lane_phase_aligner (
    .clk           (clk),
    .rst           (rst),
    .ch_word_i     (ch_word),
    .ch_strobe_i   (ch_strobe),
    .phase_o       (phase),
    .align_word_o  (word),
    .align_valid_o (valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cur_t, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired cycle=%0d actual=0 expected=1", cur_t);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20260));
    // ramp first, then random samples
    for (int t = 0; t < TMAX; t++)
      samp[t] = (t < 160) ? 3'(t) : 3'($urandom % 8);
    for (int g = 0; g < NGRP; g++) begin
      if (g < 10) grp_stb[g] = 4'hF;
      else if (($urandom % 5) == 0) grp_stb[g] = ~(4'b0001 << ($urandom % 4));
      else grp_stb[g] = 4'hF;
    end
    grp_stb[12] = 4'h0;     // R7: no strobes in group
    grp_stb[13] = 4'b0111;  // R7: lane 3 missing only
    grp_stb[14] = 4'hF;

    rst = 1'b1;
    ch_word = '0;
    ch_strobe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(word == 12'h0,  "R1 word in reset",  word,  0);
    check(valid == 1'b0,  "R1 valid in reset", valid, 0);
    check(phase == 4'b0001, "R1 phase in reset", phase, 4'b0001);
    rst = 1'b0;

    for (int t = 0; t < TMAX; t++) begin
      logic [3:0]  exp_phase;
      logic [11:0] exp_word;
      bit          exp_valid;
      int          ph;
      int          g;
      cur_t = t;
      ph = t % 4;
      g  = t / 4;
      exp_phase = 4'b0001 << ph;
      exp_word  = '0;
      exp_valid = 1'b0;
      if (t >= 13) begin
        int gg;
        gg = (t - 13) / 4;
        exp_word = {samp[4*gg+3], samp[4*gg+2], samp[4*gg+1], samp[4*gg]};
        exp_valid = (ph == 1) && (grp_stb[gg] == 4'hF);
      end
      check(phase == exp_phase, "R2 phase rotation", phase, exp_phase);
      if (t < 13) begin
        check(word == exp_word, "R8 word before first group", word, exp_word);
        check(valid == exp_valid, "R8 no early valid", valid, exp_valid);
      end else begin
        // R3 junk off-phase, R4 packing, R5 latency
        check(word == exp_word, "R5 R4 R3 aligned word", word, exp_word);
        check(valid == exp_valid, "R7 R6 valid pulse", valid, exp_valid);
      end
      // drive cycle t: own-phase lane gets real data, others junk
      for (int ln = 0; ln < 4; ln++) begin
        if (ln == ph) begin
          ch_word[3*ln +: 3] = samp[t];
          ch_strobe[ln]      = grp_stb[g][ln];
        end else begin
          ch_word[3*ln +: 3] = 3'($urandom);
          ch_strobe[ln]      = 1'($urandom);
        end
      end
      @(posedge clk);
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule